// File: doc/BRIEF.md
# Hamming (7,4) Single-Error Corrector

This block pairs an encoder and a decoder for a seven-bit Hamming code that carries four data bits behind three check bits. The encoder spreads a data nibble across the non-power-of-two positions of the codeword and fills positions 1, 2 and 4 with even-parity check bits. A test-path input can invert any one codeword position on the way out, so that a link or a bench can provoke a known single-bit fault.

The decoder recomputes the three parity groups over a received word. The resulting syndrome is the number of the faulty position, and that position is inverted. It returns the syndrome, an error flag, the repaired word and the recovered nibble together. Each side is a one-entry registered stage with valid/ready handshakes. A word is taken when `*_in_valid` and `*_in_ready` are both high on a rising edge. A result is consumed when `*_out_valid` and `*_out_ready` are both high. While a result waits with `*_out_ready` low, it is held unchanged and the stage drops `*_in_ready`. When the consumer is ready, the stage takes a new word on the same edge that it hands the old one over.

In every codeword, bit index i-1 carries position i, so position 7 is the MSB and is written leftmost.

Top module: `ham74_codec`

## Requirements
- R1: The encoder puts data bits d0, d1, d2, d3 at positions 3, 5, 6, 7 and check bits at positions 1, 2, 4. Each check bit makes its group even: position 1 covers {1,3,5,7}, position 2 covers {2,3,6,7} and position 4 covers {4,5,6,7}.
- R2: A nonzero `enc_flip_pos` of value k inverts codeword position k (bit k-1) of the encoded word. A value of 0 leaves the word untouched.
- R3: The decoder syndrome has bit 0 as the parity of group {1,3,5,7}, bit 1 as the parity of group {2,3,6,7} and bit 2 as the parity of group {4,5,6,7}. Its value therefore names one position.
- R4: When the syndrome is nonzero, the decoder inverts the position whose number the syndrome gives and raises `dec_out_err`.
- R5: When the syndrome is zero, the received word passes through unchanged and `dec_out_err` is low.
- R6: `dec_out_data` takes positions 3, 5, 6 and 7 of the repaired word, from LSB to MSB.
- R7: Both stages present their result with `*_out_valid` high one clock after the word is accepted.
- R8: While `*_out_valid` is high and `*_out_ready` is low, the output is held stable and `*_in_ready` is low. Once ready returns, a pending input is taken on that edge.
- R9: A synchronous active-high `rst` clears both output valids and all registered outputs.
- R10: The received word 1011011 (position 7 first) decodes to syndrome 5 and is repaired to 1001011, which carries data 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_in_valid | input | 1 | Encoder input word offered |
| enc_in_ready | output | 1 | Encoder can accept a word |
| enc_in_data | input | 4 | Data nibble to encode |
| enc_flip_pos | input | 3 | Position to invert on the test path (0 = none) |
| enc_out_valid | output | 1 | Encoded word available |
| enc_out_ready | input | 1 | Consumer takes the encoded word |
| enc_out_code | output | 7 | Encoded word, position 7 in the MSB |
| dec_in_valid | input | 1 | Received word offered |
| dec_in_ready | output | 1 | Decoder can accept a word |
| dec_in_code | input | 7 | Received word, position 7 in the MSB |
| dec_out_valid | output | 1 | Decode result available |
| dec_out_ready | input | 1 | Consumer takes the decode result |
| dec_out_syn | output | 3 | Syndrome (faulty position, 0 = none) |
| dec_out_err | output | 1 | Single-bit error was found and repaired |
| dec_out_fixed | output | 7 | Repaired word |
| dec_out_data | output | 4 | Recovered data nibble |

## Verification
The bench encodes all sixteen nibbles and applies every injection value from 0 to 7. It then feeds each result back through the decoder. A mistake in the group membership or the bit order therefore shows up as a wrong codeword, a wrong syndrome or a nibble that does not come back. A decoder that counts positions from zero, or that weights the syndrome bits the other way round, would repair the wrong bit and fail the worked example 1011011. The clean case checks that a zero syndrome leaves the word alone and keeps the flag low. A stalled consumer probes back-pressure: a stage that overwrote its output while stalled, or that dropped the pending word when ready returned, would show a changed code or a lost nibble.

// File: rtl/ham74_pkg.sv
package ham74_pkg;

  function automatic bit is_pow2(int x);
    is_pow2 = (x > 0) && ((x & (x - 1)) == 0);
  endfunction

  // Codeword position (1-based) of the j-th data bit.
  function automatic int data_pos(int j);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int pos = 1; pos < 64; pos++) begin
      if (!is_pow2(pos)) begin
        if (cnt == j) res = pos;
        cnt++;
      end
    end
    data_pos = res;
  endfunction

  // Index of the data bit carried at a non-power-of-two position.
  function automatic int data_idx(int pos);
    int cnt;
    cnt = 0;
    for (int q = 1; q < 64; q++) begin
      if (q < pos && !is_pow2(q)) cnt++;
    end
    data_idx = cnt;
  endfunction

  // Positions covered by check group g, bit pos-1 set when covered.
  function automatic logic [63:0] group_mask(int g, int n);
    logic [63:0] m;
    m = '0;
    for (int pos = 1; pos < 64; pos++) begin
      if (pos <= n && ((pos >> g) & 1) == 1) m[pos-1] = 1'b1;
    end
    group_mask = m;
  endfunction

endpackage

// File: rtl/ham74_syndrome.sv
module ham74_syndrome #(
  parameter int P = 3,
  localparam int N = (1 << P) - 1
) (
  input  logic [N-1:0] word,
  output logic [P-1:0] syn
);
  import ham74_pkg::*;

  for (genvar g = 0; g < P; g++) begin : g_grp
    localparam logic [63:0] MASK = group_mask(g, N);
    assign syn[g] = ^(word & MASK[N-1:0]);
  end

endmodule

// File: rtl/ham74_stage.sv
module ham74_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STAGE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid); // R7
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_STAGE_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R8
  AST_STAGE_RESET: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_data == '0)); // R9

endmodule

// File: rtl/ham74_encoder.sv
module ham74_encoder #(
  parameter int P = 3,
  localparam int N = (1 << P) - 1,
  localparam int K = N - P
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [K-1:0] in_data,
  input  logic [P-1:0] flip_pos,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_code
);
  import ham74_pkg::*;

  logic [N-1:0] spread;
  logic [N-1:0] clean;
  logic [N-1:0] flip_mask;
  logic [N-1:0] faulted;
  logic [P-1:0] checks;
  logic [P-1:0] clean_syn;

  // Data onto non-power-of-two positions, check positions left at zero.
  for (genvar pos = 1; pos <= N; pos++) begin : g_spread
    if (is_pow2(pos)) begin : g_chk
      assign spread[pos-1] = 1'b0;
    end else begin : g_dat
      assign spread[pos-1] = in_data[data_idx(pos)];
    end
  end

  ham74_syndrome #(.P(P)) u_par (.word(spread), .syn(checks));

  // Each group's parity over data lands on its power-of-two position.
  for (genvar pos = 1; pos <= N; pos++) begin : g_place
    if (is_pow2(pos)) begin : g_chk
      assign clean[pos-1] = checks[$clog2(pos)];
    end else begin : g_dat
      assign clean[pos-1] = spread[pos-1];
    end
  end

  // Test-path injection: flip_pos k inverts position k.
  for (genvar i = 0; i < N; i++) begin : g_flip
    assign flip_mask[i] = (flip_pos == P'(i + 1));
  end

  assign faulted = clean ^ flip_mask;

  ham74_stage #(.W(N)) u_stage (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(faulted),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_code)
  );

  // Independent parity check of the clean word.
  ham74_syndrome #(.P(P)) u_chk (.word(clean), .syn(clean_syn));

  AST_ENC_EVEN: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (clean_syn == '0)); // R1
  AST_ENC_FLIP: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ($countones(faulted ^ clean) == ((flip_pos != '0) ? 1 : 0))); // R2

endmodule

// File: rtl/ham74_decoder.sv
module ham74_decoder #(
  parameter int P = 3,
  localparam int N = (1 << P) - 1,
  localparam int K = N - P,
  localparam int W = P + 1 + N + K
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_code,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [P-1:0] out_syn,
  output logic         out_err,
  output logic [N-1:0] out_fixed,
  output logic [K-1:0] out_data
);
  import ham74_pkg::*;

  logic [P-1:0] syn;
  logic [N-1:0] fix_mask;
  logic [N-1:0] fixed;
  logic [K-1:0] data;
  logic         err;
  logic [W-1:0] pack_in;
  logic [W-1:0] pack_out;
  logic [P-1:0] fix_syn;

  ham74_syndrome #(.P(P)) u_syn (.word(in_code), .syn(syn));

  // Syndrome value is the 1-based position to invert.
  for (genvar i = 0; i < N; i++) begin : g_fix
    assign fix_mask[i] = (syn == P'(i + 1));
  end

  assign fixed = in_code ^ fix_mask;
  assign err   = |syn;

  for (genvar j = 0; j < K; j++) begin : g_gather
    assign data[j] = fixed[data_pos(j) - 1];
  end

  assign pack_in = {syn, err, fixed, data};

  ham74_stage #(.W(W)) u_stage (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(pack_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(pack_out)
  );

  assign {out_syn, out_err, out_fixed, out_data} = pack_out;

  // Repaired word must be a codeword.
  ham74_syndrome #(.P(P)) u_chk (.word(fixed), .syn(fix_syn));

  AST_DEC_CLEAN: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (fix_syn == '0)); // R4
  AST_DEC_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ($countones(fixed ^ in_code) == ((syn != '0) ? 1 : 0))); // R5
  AST_DEC_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_err == (out_fixed != $past(in_code)) || !$past(in_valid && in_ready))); // R4

endmodule

// File: rtl/ham74_codec.sv
module ham74_codec #(
  parameter int P = 3,
  localparam int N = (1 << P) - 1,
  localparam int K = N - P
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enc_in_valid,
  output logic         enc_in_ready,
  input  logic [K-1:0] enc_in_data,
  input  logic [P-1:0] enc_flip_pos,
  output logic         enc_out_valid,
  input  logic         enc_out_ready,
  output logic [N-1:0] enc_out_code,
  input  logic         dec_in_valid,
  output logic         dec_in_ready,
  input  logic [N-1:0] dec_in_code,
  output logic         dec_out_valid,
  input  logic         dec_out_ready,
  output logic [P-1:0] dec_out_syn,
  output logic         dec_out_err,
  output logic [N-1:0] dec_out_fixed,
  output logic [K-1:0] dec_out_data
);

  ham74_encoder #(.P(P)) u_enc (
    .clk(clk), .rst(rst),
    .in_valid(enc_in_valid), .in_ready(enc_in_ready),
    .in_data(enc_in_data), .flip_pos(enc_flip_pos),
    .out_valid(enc_out_valid), .out_ready(enc_out_ready),
    .out_code(enc_out_code)
  );

  ham74_decoder #(.P(P)) u_dec (
    .clk(clk), .rst(rst),
    .in_valid(dec_in_valid), .in_ready(dec_in_ready),
    .in_code(dec_in_code),
    .out_valid(dec_out_valid), .out_ready(dec_out_ready),
    .out_syn(dec_out_syn), .out_err(dec_out_err),
    .out_fixed(dec_out_fixed), .out_data(dec_out_data)
  );

endmodule

// File: tb/ham74_codec_bench.sv
`timescale 1ns/1ps
module ham74_codec_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enc_in_valid = 1'b0;
  logic       enc_in_ready;
  logic [3:0] enc_in_data = '0;
  logic [2:0] enc_flip_pos = '0;
  logic       enc_out_valid;
  logic       enc_out_ready = 1'b1;
  logic [6:0] enc_out_code;
  logic       dec_in_valid = 1'b0;
  logic       dec_in_ready;
  logic [6:0] dec_in_code = '0;
  logic       dec_out_valid;
  logic       dec_out_ready = 1'b1;
  logic [2:0] dec_out_syn;
  logic       dec_out_err;
  logic [6:0] dec_out_fixed;
  logic [3:0] dec_out_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Codeword per nibble, position 7 on the left: d3 d2 d1 p4 d0 p2 p1.
  localparam logic [6:0] CODES [16] = '{
    7'h00, 7'h07, 7'h19, 7'h1E, 7'h2A, 7'h2D, 7'h33, 7'h34,
    7'h4B, 7'h4C, 7'h52, 7'h55, 7'h61, 7'h66, 7'h78, 7'h7F
  };

  always #4 clk = ~clk;

  ham74_codec u_ham74_codec (
    .clk(clk), .rst(rst),
    .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready),
    .enc_in_data(enc_in_data), .enc_flip_pos(enc_flip_pos),
    .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready),
    .enc_out_code(enc_out_code),
    .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready),
    .dec_in_code(dec_in_code),
    .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready),
    .dec_out_syn(dec_out_syn), .dec_out_err(dec_out_err),
    .dec_out_fixed(dec_out_fixed), .dec_out_data(dec_out_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [6:0] word;
    logic [6:0] expw;
    repeat (3) @(negedge clk);
    chk("R9 enc valid after reset", 32'(enc_out_valid), 0);
    chk("R9 dec valid after reset", 32'(dec_out_valid), 0);
    chk("R9 dec fixed after reset", 32'(dec_out_fixed), 0);
    rst = 1'b0;

    // Table walk: every nibble, every injection value.
    for (int d = 0; d < 16; d++) begin
      for (int f = 0; f < 8; f++) begin
        @(negedge clk);
        enc_in_valid = 1'b1;
        enc_in_data  = 4'(d);
        enc_flip_pos = 3'(f);
        @(negedge clk);
        enc_in_valid = 1'b0;
        expw = CODES[d] ^ ((f != 0) ? (7'd1 << (f - 1)) : 7'd0);
        chk("R7 enc valid", 32'(enc_out_valid), 1);
        chk((f == 0) ? "R1 enc code" : "R2 enc flipped code", 32'(enc_out_code), 32'(expw));
        word = enc_out_code;
        dec_in_valid = 1'b1;
        dec_in_code  = word;
        @(negedge clk);
        dec_in_valid = 1'b0;
        chk("R7 dec valid", 32'(dec_out_valid), 1);
        chk("R3 syndrome", 32'(dec_out_syn), 32'(f));
        if (f == 0) begin
          chk("R5 no error flag", 32'(dec_out_err), 0);
          chk("R5 pass through", 32'(dec_out_fixed), 32'(word));
        end else begin
          chk("R4 error flag", 32'(dec_out_err), 1);
          chk("R4 repaired word", 32'(dec_out_fixed), 32'(CODES[d]));
        end
        chk("R6 data out", 32'(dec_out_data), 32'(d));
      end
    end

    // Worked example.
    @(negedge clk);
    dec_in_valid = 1'b1;
    dec_in_code  = 7'b1011011;
    @(negedge clk);
    dec_in_valid = 1'b0;
    chk("R10 syndrome", 32'(dec_out_syn), 5);
    chk("R10 repaired", 32'(dec_out_fixed), 32'(7'b1001011));
    chk("R10 data", 32'(dec_out_data), 8);

    // Back-pressure on the encoder.
    @(negedge clk);
    enc_out_ready = 1'b0;
    enc_in_valid  = 1'b1;
    enc_in_data   = 4'd3;
    enc_flip_pos  = 3'd0;
    @(negedge clk);
    enc_in_data = 4'd5;
    chk("R8 stalled code", 32'(enc_out_code), 32'(7'h1E));
    chk("R8 in_ready low", 32'(enc_in_ready), 0);
    @(negedge clk);
    chk("R8 code held", 32'(enc_out_code), 32'(7'h1E));
    chk("R8 valid held", 32'(enc_out_valid), 1);
    enc_out_ready = 1'b1;
    @(negedge clk);
    enc_in_valid = 1'b0;
    chk("R8 pending word taken", 32'(enc_out_code), 32'(7'h2D));
    @(negedge clk);
    chk("R8 drained", 32'(enc_out_valid), 0);

    // Reset in mid-stream.
    dec_in_valid = 1'b1;
    dec_in_code  = 7'h55;
    dec_out_ready = 1'b0;
    @(negedge clk);
    dec_in_valid = 1'b0;
    chk("R7 dec valid before reset", 32'(dec_out_valid), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    dec_out_ready = 1'b1;
    chk("R9 dec valid cleared", 32'(dec_out_valid), 0);
    chk("R9 dec data cleared", 32'(dec_out_data), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule